// File: doc/BRIEF.md
# FPU State-Frame Save/Restore Sequencer

This block runs the memory side of the two privileged floating-point state instructions: saving an idle state frame and restoring a frame from memory. A single request carries the operation, the addressing mode, the current address-register value, a precomputed effective address and the supervisor flag. For a save, the block writes the 16-bit idle header word. For a restore, it reads a header word back, works out the frame format from it, and derives the frame length.

When the access completes, the block reports the new address-register value with a one-cycle write enable. This happens only in the addressing modes that adjust the register: pre-decrement for a save and post-increment for a restore. It raises a one-cycle privilege error when a request arrives outside supervisor mode, and a one-cycle bad-frame error when a restored header matches no known format. A bus abort on the access cancels any register update. The instruction-address register of the floating-point unit is never touched, and no internal floating-point state is moved here.

Top module: `fpu_frame_seq`

## Requirements
- R1: A request with `req_super` low produces a `priv_err` pulse in the cycle after the request. It makes no memory access and gives no `areg_we`.
- R2: A save writes the header word 0xFD18. In mode 4 (pre-decrement) the write address is `req_areg` minus 0x1C. In any other mode it is `req_ea`.
- R3: A completed save in mode 4 pulses `areg_we` with `areg_out` equal to the write address. A save in any other mode never pulses `areg_we`.
- R4: A restore reads the header from `req_areg` in mode 3 (post-increment) and from `req_ea` in any other mode.
- R5: The restored header is classified in priority order: null first, then idle, then busy. A header whose bits 15:8 are 0x00 is a null frame of 4 bytes. Otherwise, bits 7:0 equal to 0x18 give an idle frame of 0x1C bytes, and bits 7:0 equal to 0xB4 give a busy frame of 0xB8 bytes. So 0x0018 and 0x00B4 are both null frames.
- R6: A completed restore of a recognised frame in mode 3 pulses `areg_we` with `areg_out` equal to `req_areg` plus the frame size. In other modes there is no `areg_we` and no error.
- R7: A completed restore of an unrecognised header pulses `bad_frame` and gives no `areg_we`.
- R8: If `mem_abort` is high while an access is pending, the access ends with no `areg_we`, no `bad_frame` and no `priv_err`. Abort takes precedence over `mem_done`.
- R9: While an access is pending, `mem_wr`/`mem_rd` and `mem_addr` hold until `mem_done` or `mem_abort`. Any `req_valid` seen during that time is ignored.
- R10: After reset, `mem_wr`, `mem_rd`, `areg_we`, `priv_err` and `bad_frame` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a save or restore |
| req_restore | input | 1 | 1 = restore, 0 = save |
| req_mode | input | 3 | Addressing mode (3 post-increment, 4 pre-decrement) |
| req_areg | input | AW | Current address-register value |
| req_ea | input | AW | Effective address for the other modes |
| req_super | input | 1 | Supervisor mode flag |
| mem_done | input | 1 | Pending access completed |
| mem_abort | input | 1 | Pending access faulted |
| mem_rdata | input | 16 | Header word read back on restore |
| mem_wr | output | 1 | Header write request |
| mem_rd | output | 1 | Header read request |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 16 | Header word to write |
| areg_we | output | 1 | Address-register update strobe |
| areg_out | output | AW | New address-register value |
| priv_err | output | 1 | Privilege violation pulse |
| bad_frame | output | 1 | Unrecognised frame pulse |

## Verification
A request accepted on a clock edge shows its memory request and address in the following cycle. The address-register strobe or bad-frame pulse appears one cycle after the edge that samples `mem_done`. A privilege error appears one cycle after the refused request. The driver applies inputs and samples on falling edges. It checks the request one falling edge after issuing it, and the monitor compares each result pulse one falling edge after the completion edge. Operations that must leave no result are confirmed quiet two cycles later, before the next request starts.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
    localparam int HW = 16;
    localparam int SZW = 8;
    localparam int NFMT = 3;
    localparam logic [2:0] MODE_POSTINC = 3'd3;
    localparam logic [2:0] MODE_PREDEC = 3'd4;
    localparam logic [HW-1:0] SAVE_HDR = 16'hFD18;
    localparam logic [SZW-1:0] SAVE_SIZE = 8'h1C;

    typedef enum logic {ST_IDLE, ST_WAIT} seq_st_e;

    // format table, index order is the match priority
    function automatic logic [HW-1:0] fmt_mask(input int i);
        return (i == 0) ? 16'hFF00 : 16'h00FF;
    endfunction
    function automatic logic [HW-1:0] fmt_value(input int i);
        return (i == 0) ? 16'h0000 : ((i == 1) ? 16'h0018 : 16'h00B4);
    endfunction
    function automatic logic [SZW-1:0] fmt_size(input int i);
        return (i == 0) ? 8'h04 : ((i == 1) ? 8'h1C : 8'hB8);
    endfunction
endpackage

// File: rtl/fsq_classify.sv
module fsq_classify
    import fsq_pkg::*;
(
    input  logic [HW-1:0]  hdr,
    output logic           known,
    output logic [SZW-1:0] size
);
    logic [NFMT-1:0] hit;

    generate
        for (genvar g = 0; g < NFMT; g++) begin : g_fmt
            assign hit[g] = ((hdr & fmt_mask(g)) == fmt_value(g));
        end
    endgenerate

    always_comb begin
        known = 1'b0;
        size = '0;
        for (int i = NFMT - 1; i >= 0; i--) begin
            if (hit[i]) begin
                known = 1'b1;
                size = fmt_size(i);
            end
        end
    end

    always_comb begin
        // R5
        if (hdr[15:8] == 8'h00) null_prio_chk: assert (size == 8'h04);
    end
endmodule

// File: rtl/fsq_addr.sv
module fsq_addr
    import fsq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          restore,
    input  logic [2:0]    mode,
    input  logic [AW-1:0] areg,
    input  logic [AW-1:0] ea,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] SAVE_LEN = AW'(SAVE_SIZE);

    always_comb begin
        if (!restore && mode == MODE_PREDEC) addr = areg - SAVE_LEN;
        else if (restore && mode == MODE_POSTINC) addr = areg;
        else addr = ea;
    end
endmodule

// File: rtl/fpu_frame_seq.sv
module fpu_frame_seq
    import fsq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_restore,
    input  logic [2:0]    req_mode,
    input  logic [AW-1:0] req_areg,
    input  logic [AW-1:0] req_ea,
    input  logic          req_super,
    input  logic          mem_done,
    input  logic          mem_abort,
    input  logic [15:0]   mem_rdata,
    output logic          mem_wr,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    output logic          areg_we,
    output logic [AW-1:0] areg_out,
    output logic          priv_err,
    output logic          bad_frame
);
    typedef struct packed {
        seq_st_e       st;
        logic          restore;
        logic [2:0]    mode;
        logic [AW-1:0] areg;
        logic [AW-1:0] addr;
        logic          we;
        logic [AW-1:0] aout;
        logic          priv;
        logic          bad;
    } seq_t;

    seq_t r_q, r_d;
    logic [AW-1:0] acc_addr;
    logic cls_known;
    logic [SZW-1:0] cls_size;

    fsq_addr #(.AW(AW)) u_addr (
        .restore(req_restore), .mode(req_mode), .areg(req_areg),
        .ea(req_ea), .addr(acc_addr)
    );

    fsq_classify u_cls (.hdr(mem_rdata), .known(cls_known), .size(cls_size));

    always_comb begin
        r_d = r_q;
        r_d.we = 1'b0;
        r_d.priv = 1'b0;
        r_d.bad = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_super) begin
                        r_d.priv = 1'b1;
                    end else begin
                        r_d.st = ST_WAIT;
                        r_d.restore = req_restore;
                        r_d.mode = req_mode;
                        r_d.areg = req_areg;
                        r_d.addr = acc_addr;
                    end
                end
            end
            default: begin
                if (mem_abort) begin
                    r_d.st = ST_IDLE;
                end else if (mem_done) begin
                    r_d.st = ST_IDLE;
                    if (!r_q.restore) begin
                        if (r_q.mode == MODE_PREDEC) begin
                            r_d.we = 1'b1;
                            r_d.aout = r_q.addr;
                        end
                    end else if (!cls_known) begin
                        r_d.bad = 1'b1;
                    end else if (r_q.mode == MODE_POSTINC) begin
                        r_d.we = 1'b1;
                        r_d.aout = r_q.areg + AW'(cls_size);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else r_q <= r_d;
    end

    assign mem_wr = (r_q.st == ST_WAIT) && !r_q.restore;
    assign mem_rd = (r_q.st == ST_WAIT) && r_q.restore;
    assign mem_addr = r_q.addr;
    assign mem_wdata = SAVE_HDR;
    assign areg_we = r_q.we;
    assign areg_out = r_q.aout;
    assign priv_err = r_q.priv;
    assign bad_frame = r_q.bad;

    // R1
    priv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        priv_err |-> (!mem_wr && !mem_rd && !areg_we));
    // R7
    bad_no_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_frame |-> !areg_we);
    // R8
    upd_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (areg_we || bad_frame) |-> $past(mem_done && !mem_abort));
    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_wr || mem_rd) && !mem_done && !mem_abort) |=>
            ($stable(mem_addr) && $stable(mem_wr) && $stable(mem_rd)));
    // R9
    one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr, mem_rd}));
endmodule

// File: tb/sim_fpu_frame_seq.sv
module sim_fpu_frame_seq;
    localparam int AW = 32;
    localparam int K_QUIET = 0, K_WE = 1, K_BAD = 2, K_PRIV = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_restore = 0, req_super = 0;
    logic [2:0] req_mode = 0;
    logic [AW-1:0] req_areg = 0, req_ea = 0;
    logic mem_done = 0, mem_abort = 0;
    logic [15:0] mem_rdata = 0;
    logic mem_wr, mem_rd, areg_we, priv_err, bad_frame;
    logic [AW-1:0] mem_addr, areg_out;
    logic [15:0] mem_wdata;

    int n_tests = 0, n_fail = 0;
    int exp_kind_q[$];
    logic [AW-1:0] exp_val_q[$];
    string exp_tag_q[$];

    always #5 clk = ~clk;

    fpu_frame_seq #(.AW(AW)) u0 (.*);

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per observed result pulse
    always @(negedge clk) begin
        if (rst_n && (areg_we || bad_frame || priv_err)) begin
            int k;
            k = areg_we ? K_WE : (bad_frame ? K_BAD : K_PRIV);
            if (exp_kind_q.size() == 0) begin
                check("unexpected result", AW'(k), AW'(K_QUIET));
            end else begin
                int ek;
                logic [AW-1:0] ev;
                string t;
                ek = exp_kind_q.pop_front();
                ev = exp_val_q.pop_front();
                t = exp_tag_q.pop_front();
                check({t, " kind"}, AW'(k), AW'(ek));
                if (ek == K_WE) check({t, " areg_out"}, areg_out, ev);
            end
        end
    end

    task automatic do_op(input string tag, input logic rst_op, input logic [2:0] mode,
                         input logic [AW-1:0] areg, input logic [AW-1:0] ea, input logic sup,
                         input logic [15:0] hdr, input logic abort, input logic extra,
                         input int ek, input logic [AW-1:0] ev);
        logic [AW-1:0] ea_exp;
        if (!rst_op && mode == 3'd4) ea_exp = areg - 32'h1C;
        else if (rst_op && mode == 3'd3) ea_exp = areg;
        else ea_exp = ea;
        exp_kind_q.push_back(ek);
        exp_val_q.push_back(ev);
        exp_tag_q.push_back(tag);
        req_valid = 1; req_restore = rst_op; req_mode = mode;
        req_areg = areg; req_ea = ea; req_super = sup;
        @(negedge clk);
        req_valid = 0;
        if (!sup) begin
            check({tag, " no access"}, AW'({mem_wr, mem_rd}), 0);
        end else begin
            check({tag, " req kind"}, AW'({mem_wr, mem_rd}), rst_op ? 32'd1 : 32'd2);
            check({tag, " addr"}, mem_addr, ea_exp);
            if (!rst_op) check({tag, " wdata"}, AW'(mem_wdata), 32'hFD18);
            if (extra) begin
                req_valid = 1; req_restore = ~rst_op; req_mode = 3'd4;
                req_areg = 32'h5555_0000; req_ea = 32'h7777_0000;
                @(negedge clk);
                req_valid = 0;
                @(negedge clk);
                check({tag, " held addr"}, mem_addr, ea_exp);
                check({tag, " held kind"}, AW'({mem_wr, mem_rd}), rst_op ? 32'd1 : 32'd2);
            end
            mem_done = 1; mem_abort = abort; mem_rdata = hdr;
            @(negedge clk);
            mem_done = 0; mem_abort = 0;
            check({tag, " access ended"}, AW'({mem_wr, mem_rd}), 0);
        end
        @(negedge clk);
        @(negedge clk);
        if (exp_kind_q.size() != 0) begin
            int ek2;
            ek2 = exp_kind_q.pop_front();
            void'(exp_val_q.pop_front());
            void'(exp_tag_q.pop_front());
            check({tag, " missing result"}, AW'(K_QUIET), AW'(ek2));
        end else begin
            n_tests++;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 outputs in reset", AW'({mem_wr, mem_rd, areg_we, priv_err, bad_frame}), 0);
        rst_n = 1;
        @(negedge clk);
        check("R10 outputs after reset", AW'({mem_wr, mem_rd, areg_we, priv_err, bad_frame}), 0);

        // R2 R3 save pre-decrement
        do_op("R2 R3 save predec", 0, 3'd4, 32'h1000, 32'h9000, 1, 0, 0, 0, K_WE, 32'h0FE4);
        do_op("R2 R3 save mode5", 0, 3'd5, 32'h1000, 32'h2000, 1, 0, 0, 0, K_QUIET, 0);
        do_op("R2 R3 save mode3", 0, 3'd3, 32'h1000, 32'h2400, 1, 0, 0, 0, K_QUIET, 0);
        // R4 R5 R6 restore post-increment
        do_op("R5 R6 null", 1, 3'd3, 32'h3000, 32'h9000, 1, 16'h0000, 0, 0, K_WE, 32'h3004);
        do_op("R5 R6 idle", 1, 3'd3, 32'h3000, 32'h9000, 1, 16'h4118, 0, 0, K_WE, 32'h301C);
        do_op("R5 R6 busy", 1, 3'd3, 32'h3000, 32'h9000, 1, 16'h41B4, 0, 0, K_WE, 32'h30B8);
        do_op("R5 prio 0018", 1, 3'd3, 32'h3000, 32'h9000, 1, 16'h0018, 0, 0, K_WE, 32'h3004);
        do_op("R5 prio 00B4", 1, 3'd3, 32'h3000, 32'h9000, 1, 16'h00B4, 0, 0, K_WE, 32'h3004);
        do_op("R4 R6 restore mode5", 1, 3'd5, 32'h3000, 32'h6000, 1, 16'h4118, 0, 0, K_QUIET, 0);
        do_op("R4 R6 restore mode4", 1, 3'd4, 32'h3000, 32'h6100, 1, 16'h41B4, 0, 0, K_QUIET, 0);
        // R7 bad frames
        do_op("R7 bad mode3", 1, 3'd3, 32'h3000, 32'h9000, 1, 16'h4155, 0, 0, K_BAD, 0);
        do_op("R7 bad mode5", 1, 3'd5, 32'h3000, 32'h9000, 1, 16'h01FF, 0, 0, K_BAD, 0);
        // R1 privilege
        do_op("R1 priv save", 0, 3'd4, 32'h1000, 32'h9000, 0, 0, 0, 0, K_PRIV, 0);
        do_op("R1 priv restore", 1, 3'd3, 32'h1000, 32'h9000, 0, 0, 0, 0, K_PRIV, 0);
        // R8 abort
        do_op("R8 abort save", 0, 3'd4, 32'h1000, 32'h9000, 1, 0, 1, 0, K_QUIET, 0);
        do_op("R8 abort restore", 1, 3'd3, 32'h3000, 32'h9000, 1, 16'h0000, 1, 0, K_QUIET, 0);
        do_op("R8 abort bad hdr", 1, 3'd3, 32'h3000, 32'h9000, 1, 16'h4155, 1, 0, K_QUIET, 0);
        // R9 hold and ignore requests while pending
        do_op("R9 busy save", 0, 3'd4, 32'h2000, 32'h9000, 1, 0, 0, 1, K_WE, 32'h1FE4);
        do_op("R9 busy restore", 1, 3'd3, 32'h4000, 32'h9000, 1, 16'h4118, 0, 1, K_WE, 32'h401C);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule